// File: doc/BRIEF.md
# Frequency and Period Measurement Counter

This block measures an external signal with a binary counter that is 20 bits wide by default. In frequency mode it counts rising edges of one of two inputs during a gate window whose length is a whole number of timebase ticks. In period mode it counts pulses of a check strobe while one or two periods of the low-frequency input elapse. A settling wait, also measured in timebase ticks, always comes before the gate or period window.

A controller applies a configuration with a one-cycle load strobe. A load with the start bit low clears the counter and stops it. A load with the start bit high begins a new wait-then-measure sequence. This second kind of load does not clear the count, so repeated starts add their results together. The controller reads the result after the complete flag rises, and before it clears the counter. All inputs, including the measured signals and both tick strobes, are synchronous to `clk`. An input edge is a sample at 1 following a sample at 0.

Top module: `meas_counter`

## Requirements
- R1: After reset `result` is 0, `done` is 0 and `overflow` is 0, and the counter is idle.
- R2: A cycle with `cfg_load`=1 and `cfg_start`=0 makes `result` 0, `done` 0 and `overflow` 0 from the next cycle on, and nothing is counted until a later start.
- R3: A start load is followed by a wait before any counting. The wait is 2 `ms_tick` pulses when `cfg_fast_wait`=1. When `cfg_fast_wait`=0 it is 4 pulses for `cfg_gate[1]`=0 and 8 pulses for `cfg_gate[1]`=1. A tick sampled in the load cycle itself is not counted.
- R4: In frequency mode the gate lasts 4, 8, 32 or 64 `ms_tick` pulses for `cfg_gate` = 0, 1, 2, 3. Qualified input edges sampled from the cycle after the wait ends up to and including the cycle of the last gate tick are counted. In freq mode, done therefore rises wait+gate ticks after the load.
- R5: `cfg_sel_hi`=1 selects `hf_in` in frequency mode, with a divide-by-2: only every second rising edge since the last load is counted. `cfg_sel_hi`=0 with `cfg_sel_freq`=1 counts every rising edge of `lf_in`. `cfg_sel_hi`=0 with `cfg_sel_freq`=0 selects period mode on `lf_in`.
- R6: In period mode, the window opens at the first `lf_in` rising edge after the wait. The window closes at the first following rising edge when `cfg_gate[1]`=0, and at the second when `cfg_gate[1]`=1. Every cycle with `chk_tick`=1 after the opening cycle, up to and including the closing cycle, adds one. With `chk_tick` held high, the result is therefore the window length in clock cycles.
- R7: `done` rises in the cycle after the window closes and then stays high until the next load. While `done` is high, `result` does not change.
- R8: A load with `cfg_start`=1 keeps the present count, so consecutive measurements accumulate. Each clock cycle raises `result` by 0 or 1, modulo 2^CNT_W.
- R9: Incrementing past the all-ones value wraps `result` to 0 and sets `overflow`. `overflow` stays set until a clearing load.
- R10: A load takes priority over a window closing in the same cycle. In that case `done` stays 0, no edge is counted in that cycle, and the new wait starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that applies the configuration bits below |
| cfg_start | input | 1 | 1: start a measurement (keep count); 0: clear and stop |
| cfg_sel_hi | input | 1 | 1: count the high-frequency input (halved) in frequency mode |
| cfg_sel_freq | input | 1 | With cfg_sel_hi=0: 1 frequency mode, 0 period mode on lf_in |
| cfg_gate | input | 2 | Gate length code; bit 1 also picks the long wait and the two-period window |
| cfg_fast_wait | input | 1 | 1: short 2-tick wait |
| ms_tick | input | 1 | Timebase strobe, one cycle per tick |
| chk_tick | input | 1 | Check strobe counted in period mode |
| hf_in | input | 1 | High-frequency measured input |
| lf_in | input | 1 | Low-frequency measured input |
| result | output | CNT_W | Count value, bit 0 is the LSB |
| done | output | 1 | Measurement window has closed |
| overflow | output | 1 | Sticky wrap indicator |

## Verification
Two events can fall in the same clock edge: a controller load and the closing of a gate window on its last timebase tick. The bench counts timebase ticks after a start. It then asserts the load so that it lands on exactly the tick that would end the gate. The result is judged as correct only if `done` stays low and `result` keeps the value it had before that edge. A later measurement must then resume from that value. A second instance with a 10-bit counter runs on the same stimulus, which brings the wrap and the sticky flag within reach.

// File: rtl/mctr_pkg.sv
package mctr_pkg;

  localparam int TMR_W       = 7;
  localparam int WAIT_FAST   = 2;
  localparam int WAIT_SHORTG = 4;
  localparam int WAIT_LONGG  = 8;
  localparam int GATE_T0     = 4;
  localparam int GATE_T1     = 8;
  localparam int GATE_T2     = 32;
  localparam int GATE_T3     = 64;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_GATE = 3'd2,
    ST_ARM  = 3'd3,
    ST_PER  = 3'd4,
    ST_DONE = 3'd5
  } mctr_st_e;

  function automatic logic [TMR_W-1:0] wait_len(input logic fast, input logic long_gate);
    if (fast)           return TMR_W'(WAIT_FAST);
    else if (long_gate) return TMR_W'(WAIT_LONGG);
    else                return TMR_W'(WAIT_SHORTG);
  endfunction

  function automatic logic [TMR_W-1:0] gate_len(input logic [1:0] code);
    case (code)
      2'd0:    return TMR_W'(GATE_T0);
      2'd1:    return TMR_W'(GATE_T1);
      2'd2:    return TMR_W'(GATE_T2);
      default: return TMR_W'(GATE_T3);
    endcase
  endfunction

endpackage

// File: rtl/mctr_edge.sv
module mctr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_hi,
  input  logic hf_in,
  input  logic lf_in,
  output logic freq_evt,
  output logic lf_rise
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] rise;
  logic            half_q;

  assign raw = {lf_in, hf_in};

  for (genvar i = 0; i < NSRC; i++) begin : g_det
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= raw[i];
    end
    assign rise[i] = raw[i] & ~prev_q;
  end

  // divide-by-2 phase of the fast input, realigned at every load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       half_q <= 1'b0;
    else if (restart) half_q <= 1'b0;
    else if (rise[0]) half_q <= ~half_q;
  end

  assign lf_rise  = rise[1];
  assign freq_evt = sel_hi ? (rise[0] & half_q) : rise[1];

endmodule

// File: rtl/mctr_seq.sv
module mctr_seq
  import mctr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       start,
  input  logic       freq_mode,
  input  logic [1:0] gate_code,
  input  logic       fast_wait,
  input  logic       ms_tick,
  input  logic       chk_tick,
  input  logic       freq_evt,
  input  logic       lf_rise,
  output logic       cnt_inc,
  output logic       win_close,
  output mctr_st_e   state
);
  logic [TMR_W-1:0] tcnt;
  logic [TMR_W-1:0] tcnt_nxt;
  logic             pcnt;
  logic             wait_end;
  logic             gate_end;
  logic             per_end;

  assign tcnt_nxt = tcnt + 1'b1;
  assign wait_end = (state == ST_WAIT) && ms_tick && (tcnt_nxt == wait_len(fast_wait, gate_code[1]));
  assign gate_end = (state == ST_GATE) && ms_tick && (tcnt_nxt == gate_len(gate_code));
  assign per_end  = (state == ST_PER) && lf_rise && (pcnt == gate_code[1]);

  assign win_close = !load && (gate_end || per_end);
  assign cnt_inc   = !load && (((state == ST_GATE) && freq_evt) ||
                               ((state == ST_PER) && chk_tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      tcnt  <= '0;
      pcnt  <= 1'b0;
    end else if (load) begin
      state <= start ? ST_WAIT : ST_IDLE;
      tcnt  <= '0;
      pcnt  <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: if (ms_tick) begin
          if (wait_end) begin
            state <= freq_mode ? ST_GATE : ST_ARM;
            tcnt  <= '0;
          end else begin
            tcnt <= tcnt_nxt;
          end
        end
        ST_GATE: if (ms_tick) begin
          if (gate_end) state <= ST_DONE;
          else          tcnt  <= tcnt_nxt;
        end
        ST_ARM: if (lf_rise) begin
          state <= ST_PER;
          pcnt  <= 1'b0;
        end
        ST_PER: if (lf_rise) begin
          if (per_end) state <= ST_DONE;
          else         pcnt  <= 1'b1;
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/mctr_accum.sv
module mctr_accum #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             clear,
  input  logic             inc,
  input  logic             close,
  output logic [CNT_W-1:0] value,
  output logic             done,
  output logic             wrap
);
  function automatic logic [CNT_W:0] bump(input logic [CNT_W-1:0] v);
    return {1'b0, v} + 1'b1;
  endfunction

  logic [CNT_W:0] nxt;
  assign nxt = bump(value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      done  <= 1'b0;
      wrap  <= 1'b0;
    end else if (clear) begin
      value <= '0;
      done  <= 1'b0;
      wrap  <= 1'b0;
    end else begin
      if (load)       done <= 1'b0;
      else if (close) done <= 1'b1;
      if (inc) begin
        value <= nxt[CNT_W-1:0];
        if (nxt[CNT_W]) wrap <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/meas_counter.sv
module meas_counter
  import mctr_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic             cfg_start,
  input  logic             cfg_sel_hi,
  input  logic             cfg_sel_freq,
  input  logic [1:0]       cfg_gate,
  input  logic             cfg_fast_wait,
  input  logic             ms_tick,
  input  logic             chk_tick,
  input  logic             hf_in,
  input  logic             lf_in,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             overflow
);
  logic       sel_hi_q;
  logic       sel_freq_q;
  logic [1:0] gate_q;
  logic       fast_q;

  logic       freq_evt;
  logic       lf_rise;
  logic       cnt_inc;
  logic       win_close;
  logic       clr_req;
  mctr_st_e   state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi_q   <= 1'b0;
      sel_freq_q <= 1'b0;
      gate_q     <= 2'd0;
      fast_q     <= 1'b0;
    end else if (cfg_load) begin
      sel_hi_q   <= cfg_sel_hi;
      sel_freq_q <= cfg_sel_freq;
      gate_q     <= cfg_gate;
      fast_q     <= cfg_fast_wait;
    end
  end

  assign clr_req = cfg_load && !cfg_start;

  mctr_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cfg_load),
    .sel_hi   (sel_hi_q),
    .hf_in    (hf_in),
    .lf_in    (lf_in),
    .freq_evt (freq_evt),
    .lf_rise  (lf_rise)
  );

  mctr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .start     (cfg_start),
    .freq_mode (sel_hi_q | sel_freq_q),
    .gate_code (gate_q),
    .fast_wait (fast_q),
    .ms_tick   (ms_tick),
    .chk_tick  (chk_tick),
    .freq_evt  (freq_evt),
    .lf_rise   (lf_rise),
    .cnt_inc   (cnt_inc),
    .win_close (win_close),
    .state     (state)
  );

  mctr_accum #(.CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .clear (clr_req),
    .inc   (cnt_inc),
    .close (win_close),
    .value (result),
    .done  (done),
    .wrap  (overflow)
  );

endmodule

// File: rtl/mctr_chk.sv
module mctr_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             cfg_start,
  input logic [CNT_W-1:0] result,
  input logic             done,
  input logic             overflow,
  input logic             win_close,
  input logic             cnt_inc
);
  AST_CLEAR_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !cfg_start) |=> (result == '0 && !done && !overflow)); // R2

  AST_DONE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> done); // R7

  AST_DONE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_load) |=> $stable(result)); // R7

  AST_LOAD_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !done); // R10

  AST_START_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_start) |=> (result == $past(result))); // R8

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> (result == $past(result) || result == CNT_W'($past(result) + 1'b1))); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !cfg_load) |=> overflow); // R9

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_inc && (&result)) |=> (overflow && result == '0)); // R9

endmodule

bind meas_counter mctr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_load  (cfg_load),
  .cfg_start (cfg_start),
  .result    (result),
  .done      (done),
  .overflow  (overflow),
  .win_close (win_close),
  .cnt_inc   (cnt_inc)
);

// File: tb/meas_counter_test.sv
`timescale 1ns/1ps
module meas_counter_test;
  localparam int W    = 20;
  localparam int NW   = 10;
  localparam int TICK = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_start = 1'b0, cfg_sel_hi = 1'b0, cfg_sel_freq = 1'b0;
  logic [1:0] cfg_gate = 2'd0;
  logic cfg_fast_wait = 1'b0;
  logic ms_tick = 1'b0, chk_tick = 1'b0, hf_in = 1'b0, lf_in = 1'b0;
  logic [W-1:0]  result;
  logic [NW-1:0] result_n;
  logic done, overflow, done_n, overflow_n;

  int n_chk = 0, n_bad = 0, trk_bad = 0;
  int cyc = 0;
  bit hf_rand = 0, lf_rand = 0, lf_per = 0, chk_all = 0, summary_done = 0;
  int lf_half = 20;

  always #2.5 clk = ~clk;

  meas_counter #(.CNT_W(W)) uut (.clk, .rst_n, .cfg_load, .cfg_start, .cfg_sel_hi,
    .cfg_sel_freq, .cfg_gate, .cfg_fast_wait, .ms_tick, .chk_tick, .hf_in, .lf_in,
    .result(result), .done(done), .overflow(overflow));

  meas_counter #(.CNT_W(NW)) uut_nar (.clk, .rst_n, .cfg_load, .cfg_start, .cfg_sel_hi,
    .cfg_sel_freq, .cfg_gate, .cfg_fast_wait, .ms_tick, .chk_tick, .hf_in, .lf_in,
    .result(result_n), .done(done_n), .overflow(overflow_n));

  // stimulus for measured inputs and strobes, changed just after each edge
  always @(posedge clk) begin
    #1;
    cyc++;
    ms_tick  <= (cyc % TICK == 0);
    hf_in    <= hf_rand ? 1'($urandom % 2) : 1'b0;
    lf_in    <= lf_per ? 1'((cyc / lf_half) % 2) : (lf_rand ? 1'($urandom % 2) : 1'b0);
    chk_tick <= chk_all ? 1'b1 : ($urandom % 4 == 0);
  end

  // reference model written from the requirements
  function automatic int exp_wait(input bit fast, input bit g1);
    return fast ? 2 : (g1 ? 8 : 4);
  endfunction
  function automatic int exp_gate(input bit [1:0] g);
    return 4 << (g[0] + 3 * g[1]);   // 4, 8, 32, 64
  endfunction

  int  m_tot = 0, m_t = 0, m_p = 0, m_ph = 0;
  bit  m_done = 0, m_half = 0, hf_p = 0, lf_p = 0;
  bit  m_hi = 0, m_fr = 0, m_fast = 0;
  bit [1:0] m_g = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tot <= 0; m_ph <= 0; m_done <= 0; m_half <= 0; hf_p <= 0; lf_p <= 0;
    end else begin
      bit hr, lr, ev;
      hr = hf_in && !hf_p;
      lr = lf_in && !lf_p;
      hf_p <= hf_in;
      lf_p <= lf_in;
      if (cfg_load) begin
        m_half <= 0; m_done <= 0; m_t <= 0; m_p <= 0;
        m_hi <= cfg_sel_hi; m_fr <= cfg_sel_freq; m_g <= cfg_gate; m_fast <= cfg_fast_wait;
        if (cfg_start) m_ph <= 1;
        else begin m_ph <= 0; m_tot <= 0; end
      end else begin
        if (hr) m_half <= !m_half;
        ev = m_hi ? (hr && m_half) : lr;
        case (m_ph)
          1: if (ms_tick) begin
               if (m_t + 1 == exp_wait(m_fast, m_g[1])) begin
                 m_ph <= (m_hi || m_fr) ? 2 : 3; m_t <= 0;
               end else m_t <= m_t + 1;
             end
          2: begin
               if (ev) m_tot <= m_tot + 1;
               if (ms_tick) begin
                 if (m_t + 1 == exp_gate(m_g)) begin m_ph <= 5; m_done <= 1; end
                 else m_t <= m_t + 1;
               end
             end
          3: if (lr) begin m_ph <= 4; m_p <= 0; end
          4: begin
               if (chk_tick) m_tot <= m_tot + 1;
               if (lr) begin
                 if (m_p == int'(m_g[1])) begin m_ph <= 5; m_done <= 1; end
                 else m_p <= m_p + 1;
               end
             end
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle tracking of both instances against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (result != W'(m_tot) || done != m_done || overflow != (m_tot >= (1 << W)) ||
          result_n != NW'(m_tot) || done_n != m_done || overflow_n != (m_tot >= (1 << NW)))
        trk_bad++;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input bit st, input bit hi, input bit fr, input bit [1:0] g, input bit fast);
    @(negedge clk);
    cfg_load = 1; cfg_start = st; cfg_sel_hi = hi; cfg_sel_freq = fr;
    cfg_gate = g; cfg_fast_wait = fast;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic wait_done(output int ticks);
    int lim;
    ticks = 0;
    lim = 0;
    while (!done && lim < 6000) begin
      if (ms_tick) ticks++;
      @(negedge clk);
      lim++;
    end
    if (!done) check("R7 done timeout", 0, 1);
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int tk;
    logic [W-1:0] held;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 result", result, 0);
    check("R1 done", done, 0);
    check("R1 overflow", overflow, 0);

    // R3 R4: wait + gate length in ticks, lf frequency counting
    lf_rand = 1;
    do_load(1, 0, 1, 2'd0, 1); wait_done(tk); check("R3 R4 fast wait, gate 0", tk, 6);
    do_load(1, 0, 1, 2'd0, 0); wait_done(tk); check("R3 R4 std wait, gate 0", tk, 8);
    do_load(1, 0, 1, 2'd1, 0); wait_done(tk); check("R3 R4 std wait, gate 1", tk, 12);
    do_load(1, 0, 1, 2'd2, 1); wait_done(tk); check("R3 R4 fast wait, gate 2", tk, 34);
    do_load(1, 0, 1, 2'd3, 0); wait_done(tk); check("R3 R4 long wait, gate 3", tk, 72);
    check("R8 accumulated lf count", result, W'(m_tot));

    // R2: clear
    do_load(0, 0, 1, 2'd0, 0);
    @(negedge clk);
    check("R2 cleared result", result, 0);
    check("R2 cleared done", done, 0);
    repeat (40) @(negedge clk);
    check("R2 stays idle", result, 0);

    // R6 R8: period mode, check strobe every cycle, lf period 40 cycles
    lf_rand = 0; lf_per = 1; lf_half = 20; chk_all = 1;
    do_load(1, 0, 0, 2'd0, 1); wait_done(tk);
    check("R6 one period", result, 40);
    repeat (10) @(negedge clk);
    check("R7 held while done", result, 40);
    do_load(1, 0, 0, 2'd2, 1); wait_done(tk);
    check("R6 R8 two periods added", result, 120);

    // R9: wrap on the narrow instance
    do_load(0, 0, 0, 2'd0, 1);
    lf_half = 600;
    do_load(1, 0, 0, 2'd0, 1); wait_done(tk);
    check("R6 wide 1200-cycle period", result, 1200);
    check("R9 narrow wrapped value", result_n, 1200 - 1024);
    check("R9 narrow overflow", overflow_n, 1);
    check("R9 wide no overflow", overflow, 0);
    do_load(0, 0, 0, 2'd0, 1);
    @(negedge clk);
    check("R2 R9 overflow cleared", overflow_n, 0);

    // R10: load on the same edge as the closing gate tick
    lf_per = 0; lf_rand = 1; chk_all = 0;
    do_load(1, 0, 1, 2'd0, 1);
    tk = 0;
    while (!(ms_tick && tk == 5)) begin
      if (ms_tick) tk++;
      @(negedge clk);
    end
    held = result;
    cfg_load = 1; cfg_start = 1;
    @(negedge clk);
    cfg_load = 0;
    check("R10 done suppressed", done, 0);
    check("R10 no count on load edge", result, held);
    wait_done(tk);
    check("R10 restarted window", tk, 6);

    // R4 R5 R6 R8: constrained-random configurations
    hf_rand = 1;
    for (int i = 0; i < 8; i++) begin
      bit [1:0] g;
      bit hi, fr, fast;
      g = 2'($urandom % 4); hi = 1'($urandom % 2); fr = 1'($urandom % 2);
      fast = 1'($urandom % 2);
      if (i == 0) begin hi = 1; fr = 0; end
      if (i == 1) begin hi = 0; fr = 0; end
      do_load(1, hi, fr, g, fast);
      wait_done(tk);
      check("R5 random run result", result, W'(m_tot));
      check("R9 random run narrow result", result_n, NW'(m_tot));
    end

    check("R4 R5 R6 cycle tracking mismatches", trk_bad, 0);
    finish_run();
  end

endmodule